// File: doc/BRIEF.md
# First/Next Error Logger

This block records hardware error events so that software can later tell whether a single fault happened or several. Each cycle it samples a vector of error-source strobes. The first error to arrive after the log was empty goes into a first-error register, and the block stores the address, command and data that were present with it. Any error that arrives while that first entry is still held goes into a second, next-error register instead. A repeat of the very source that was logged first also goes there.

One source, a correctable single-bit memory error, is handled as a special case. It never blocks the other sources, so software can poll it as a periodic counter without hiding a later serious fault. If several errors arrive in one cycle while the log is empty, they are all recorded as first errors. Software clears bits in either register by writing ones to them. Two registered summary flags report whether the log holds a single error or multiple errors.

Top module: `err_log_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `first_q`, `next_q`, the context outputs, `ctx_valid`, `single_err` and `multi_err` are all zero.
- R2: When no blocking bit is set in `first_q`, every blocking source strobed in `err_vld` has its bit set in `first_q` one cycle later. Such an event sets no new blocking bit in `next_q`. All sources except bit 0 are blocking.
- R3: When any blocking bit is set in `first_q`, every blocking source strobed in `err_vld` has its bit set in `next_q` one cycle later, and no new blocking bit appears in `first_q`. This includes a source equal to one already held in `first_q`.
- R4: Several blocking sources strobed in the same cycle while no blocking bit is held all set their `first_q` bits, and none of them sets a `next_q` bit.
- R5: Source bit 0 is the correctable single-bit error. It sets `first_q[0]` whenever `first_q[0]` is clear, whatever other bits are set. When `first_q[0]` is already set, it sets `next_q[0]` instead. It never moves a blocking source into `next_q`.
- R6: `ctx_addr`, `ctx_cmd` and `ctx_data` load the `err_addr`, `err_cmd` and `err_data` of the cycle in which a blocking source is logged into an empty `first_q`. They hold while any blocking first bit stays set, so capture re-arms only once all blocking first bits are cleared. Bit 0 alone never captures context.
- R7: When `clr_first_we` or `clr_next_we` is high, the bits set in the matching mask are cleared one cycle later. A new event for the same bit in the same cycle wins over the clear. The choice between first and next uses the register value from before the clear.
- R8: `single_err` is 1 exactly when `first_q` is nonzero and `next_q` is zero. `multi_err` is 1 exactly when both are nonzero. Both flags are aligned with the registers.
- R9: `ctx_valid` is 1 exactly when at least one blocking bit of `first_q` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_vld | input | NSRC | One strobe per error source, bit 0 is the correctable single-bit error |
| err_addr | input | AW | Address associated with this cycle's errors |
| err_cmd | input | CW | Command associated with this cycle's errors |
| err_data | input | DW | Data associated with this cycle's errors |
| clr_first_we | input | 1 | Apply `clr_first_mask` to the first-error register |
| clr_first_mask | input | NSRC | Write-1-to-clear mask for first-error bits |
| clr_next_we | input | 1 | Apply `clr_next_mask` to the next-error register |
| clr_next_mask | input | NSRC | Write-1-to-clear mask for next-error bits |
| first_q | output | NSRC | First-error register |
| next_q | output | NSRC | Next-error register |
| ctx_addr | output | AW | Captured address of the first blocking error |
| ctx_cmd | output | CW | Captured command of the first blocking error |
| ctx_data | output | DW | Captured data of the first blocking error |
| ctx_valid | output | 1 | Context belongs to a currently held blocking first error |
| single_err | output | 1 | Exactly one error episode is logged |
| multi_err | output | 1 | More than one error has been logged |

## Verification
The hardest situation to reach from the ports is a write-1-to-clear that empties the first-error register in the same cycle as a new error arrives. The new error must still be routed to the next-error register, because the routing decision uses the pre-clear value. Capture must then re-arm only for a later error. Random stimulus rarely lines these up, so a directed sequence builds that cycle on purpose. Another directed sequence mixes the correctable bit with held blocking errors. A bench model then follows long random runs in which sparse multi-bit strobes and occasional partial clears drive both registers through every routing case.

// File: rtl/err_log_pkg.sv
package err_log_pkg;

  localparam int unsigned DEF_NSRC   = 16;
  localparam int unsigned DEF_AW     = 32;
  localparam int unsigned DEF_CW     = 8;
  localparam int unsigned DEF_DW     = 64;
  localparam int unsigned DEF_NB_IDX = 0;

  // Where a single source strobe is routed in a given cycle.
  typedef enum logic [1:0] {
    ROUTE_NONE  = 2'd0,
    ROUTE_FIRST = 2'd1,
    ROUTE_NEXT  = 2'd2
  } route_e;

endpackage

// File: rtl/err_log_route.sv
module err_log_route
  import err_log_pkg::*;
#(
  parameter int unsigned NSRC   = DEF_NSRC,
  parameter int unsigned NB_IDX = DEF_NB_IDX
) (
  input  logic [NSRC-1:0] err_vld,
  input  logic [NSRC-1:0] first_q,
  output logic [NSRC-1:0] first_set,
  output logic [NSRC-1:0] next_set,
  output logic            capture
);

  localparam logic [NSRC-1:0] BLK_MASK = ~(NSRC'(1) << NB_IDX);

  logic blocked;
  assign blocked = |(first_q & BLK_MASK);

  // Context is taken only when a blocking source opens a new episode.
  assign capture = !blocked && (|(err_vld & BLK_MASK));

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    route_e route;

    if (i == NB_IDX) begin : g_nonblk
      // Correctable bit: blocked only by its own first bit.
      always_comb begin
        if (!err_vld[i])       route = ROUTE_NONE;
        else if (!first_q[i])  route = ROUTE_FIRST;
        else                   route = ROUTE_NEXT;
      end
    end else begin : g_blk
      always_comb begin
        if (!err_vld[i])       route = ROUTE_NONE;
        else if (!blocked)     route = ROUTE_FIRST;
        else                   route = ROUTE_NEXT;
      end
    end

    assign first_set[i] = (route == ROUTE_FIRST);
    assign next_set[i]  = (route == ROUTE_NEXT);
  end

endmodule

// File: rtl/err_log_w1c_reg.sv
module err_log_w1c_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_mask,
  input  logic [WIDTH-1:0] set_bits,
  output logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;
  // A set in the same cycle wins over a clear.
  assign nxt     = (q & ~clr_eff) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

endmodule

// File: rtl/err_log_ctx.sv
module err_log_ctx #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 8,
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic [CW-1:0] in_cmd,
  input  logic [DW-1:0] in_data,
  output logic [AW-1:0] ctx_addr,
  output logic [CW-1:0] ctx_cmd,
  output logic [DW-1:0] ctx_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_addr <= '0;
      ctx_cmd  <= '0;
      ctx_data <= '0;
    end else if (capture) begin
      ctx_addr <= in_addr;
      ctx_cmd  <= in_cmd;
      ctx_data <= in_data;
    end
  end

endmodule

// File: rtl/err_log_top.sv
module err_log_top
  import err_log_pkg::*;
#(
  parameter int unsigned NSRC   = DEF_NSRC,
  parameter int unsigned AW     = DEF_AW,
  parameter int unsigned CW     = DEF_CW,
  parameter int unsigned DW     = DEF_DW,
  parameter int unsigned NB_IDX = DEF_NB_IDX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] err_vld,
  input  logic [AW-1:0]   err_addr,
  input  logic [CW-1:0]   err_cmd,
  input  logic [DW-1:0]   err_data,
  input  logic            clr_first_we,
  input  logic [NSRC-1:0] clr_first_mask,
  input  logic            clr_next_we,
  input  logic [NSRC-1:0] clr_next_mask,
  output logic [NSRC-1:0] first_q,
  output logic [NSRC-1:0] next_q,
  output logic [AW-1:0]   ctx_addr,
  output logic [CW-1:0]   ctx_cmd,
  output logic [DW-1:0]   ctx_data,
  output logic            ctx_valid,
  output logic            single_err,
  output logic            multi_err
);

  localparam logic [NSRC-1:0] BLK_MASK = ~(NSRC'(1) << NB_IDX);

  logic [NSRC-1:0] first_set, next_set;
  logic [NSRC-1:0] first_nxt, next_nxt;
  logic            capture;

  err_log_route #(.NSRC(NSRC), .NB_IDX(NB_IDX)) u_route (
    .err_vld   (err_vld),
    .first_q   (first_q),
    .first_set (first_set),
    .next_set  (next_set),
    .capture   (capture)
  );

  err_log_w1c_reg #(.WIDTH(NSRC)) u_first (
    .clk      (clk),
    .rst      (rst),
    .clr_we   (clr_first_we),
    .clr_mask (clr_first_mask),
    .set_bits (first_set),
    .nxt      (first_nxt),
    .q        (first_q)
  );

  err_log_w1c_reg #(.WIDTH(NSRC)) u_next (
    .clk      (clk),
    .rst      (rst),
    .clr_we   (clr_next_we),
    .clr_mask (clr_next_mask),
    .set_bits (next_set),
    .nxt      (next_nxt),
    .q        (next_q)
  );

  err_log_ctx #(.AW(AW), .CW(CW), .DW(DW)) u_ctx (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .in_addr  (err_addr),
    .in_cmd   (err_cmd),
    .in_data  (err_data),
    .ctx_addr (ctx_addr),
    .ctx_cmd  (ctx_cmd),
    .ctx_data (ctx_data)
  );

  // Summary flags come from the next-state values so they line up with the registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      single_err <= 1'b0;
      multi_err  <= 1'b0;
      ctx_valid  <= 1'b0;
    end else begin
      single_err <= (|first_nxt) && !(|next_nxt);
      multi_err  <= (|first_nxt) && (|next_nxt);
      ctx_valid  <= |(first_nxt & BLK_MASK);
    end
  end

endmodule

// File: rtl/err_log_chk.sv
module err_log_chk #(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned AW     = 32,
  parameter int unsigned CW     = 8,
  parameter int unsigned DW     = 64,
  parameter int unsigned NB_IDX = 0
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] err_vld,
  input logic [NSRC-1:0] first_q,
  input logic [NSRC-1:0] next_q,
  input logic [AW-1:0]   ctx_addr,
  input logic [CW-1:0]   ctx_cmd,
  input logic [DW-1:0]   ctx_data,
  input logic            ctx_valid,
  input logic            single_err,
  input logic            multi_err
);

  localparam logic [NSRC-1:0] BM = ~(NSRC'(1) << NB_IDX);

  assert_first_log_R2: assert property (@(posedge clk) disable iff (rst)
    ((first_q & BM) == '0) |=>
      ((first_q & $past(err_vld & BM)) == $past(err_vld & BM)));

  assert_first_no_next_R2: assert property (@(posedge clk) disable iff (rst)
    ((first_q & BM) == '0) |=> ((next_q & ~$past(next_q) & BM) == '0));

  assert_next_log_R3: assert property (@(posedge clk) disable iff (rst)
    ((first_q & BM) != '0) |=>
      ((next_q & $past(err_vld & BM)) == $past(err_vld & BM)));

  assert_no_new_first_R3: assert property (@(posedge clk) disable iff (rst)
    ((first_q & BM) != '0) |=> ((first_q & ~$past(first_q) & BM) == '0));

  assert_corr_first_R5: assert property (@(posedge clk) disable iff (rst)
    (!first_q[NB_IDX] && err_vld[NB_IDX]) |=> first_q[NB_IDX]);

  assert_corr_next_R5: assert property (@(posedge clk) disable iff (rst)
    (first_q[NB_IDX] && err_vld[NB_IDX]) |=> next_q[NB_IDX]);

  assert_ctx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((first_q & BM) != '0) |=>
      ($stable(ctx_addr) && $stable(ctx_cmd) && $stable(ctx_data)));

  assert_multi_R8: assert property (@(posedge clk) disable iff (rst)
    multi_err |-> (first_q != '0 && next_q != '0));

  assert_single_R8: assert property (@(posedge clk) disable iff (rst)
    single_err |-> (first_q != '0 && next_q == '0));

  assert_ctx_valid_R9: assert property (@(posedge clk) disable iff (rst)
    ctx_valid |-> ((first_q & BM) != '0));

endmodule

bind err_log_top err_log_chk #(
  .NSRC(NSRC), .AW(AW), .CW(CW), .DW(DW), .NB_IDX(NB_IDX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .err_vld    (err_vld),
  .first_q    (first_q),
  .next_q     (next_q),
  .ctx_addr   (ctx_addr),
  .ctx_cmd    (ctx_cmd),
  .ctx_data   (ctx_data),
  .ctx_valid  (ctx_valid),
  .single_err (single_err),
  .multi_err  (multi_err)
);

// File: tb/err_log_top_tb.sv
module err_log_top_tb;

  localparam int NSRC = 16;
  localparam int AW   = 32;
  localparam int CW   = 8;
  localparam int DW   = 64;
  localparam int NB   = 0;
  localparam logic [NSRC-1:0] BM = ~(NSRC'(1) << NB);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] err_vld = '0;
  logic [AW-1:0]   err_addr = '0;
  logic [CW-1:0]   err_cmd = '0;
  logic [DW-1:0]   err_data = '0;
  logic            clr_first_we = 1'b0;
  logic [NSRC-1:0] clr_first_mask = '0;
  logic            clr_next_we = 1'b0;
  logic [NSRC-1:0] clr_next_mask = '0;
  logic [NSRC-1:0] first_q, next_q;
  logic [AW-1:0]   ctx_addr;
  logic [CW-1:0]   ctx_cmd;
  logic [DW-1:0]   ctx_data;
  logic            ctx_valid, single_err, multi_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of the expected register state
  logic [NSRC-1:0] m_first = '0, m_next = '0;
  logic [AW-1:0]   m_addr = '0;
  logic [CW-1:0]   m_cmd = '0;
  logic [DW-1:0]   m_data = '0;
  logic            m_cv = 1'b0, m_single = 1'b0, m_multi = 1'b0;

  always #4 clk = ~clk;

  err_log_top u_dut (
    .clk(clk), .rst(rst), .err_vld(err_vld), .err_addr(err_addr),
    .err_cmd(err_cmd), .err_data(err_data),
    .clr_first_we(clr_first_we), .clr_first_mask(clr_first_mask),
    .clr_next_we(clr_next_we), .clr_next_mask(clr_next_mask),
    .first_q(first_q), .next_q(next_q), .ctx_addr(ctx_addr),
    .ctx_cmd(ctx_cmd), .ctx_data(ctx_data), .ctx_valid(ctx_valid),
    .single_err(single_err), .multi_err(multi_err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NSRC-1:0] route_first(input logic [NSRC-1:0] f,
                                                  input logic [NSRC-1:0] e);
    logic [NSRC-1:0] r = '0;
    for (int i = 0; i < NSRC; i++)
      if (e[i]) r[i] = (i == NB) ? !f[i] : ((f & BM) == '0);
    return r;
  endfunction

  task automatic model_step();
    logic [NSRC-1:0] fs, ns, cf, cn;
    logic cap;
    fs  = route_first(m_first, err_vld);
    ns  = err_vld & ~fs;
    cap = ((m_first & BM) == '0) && ((err_vld & BM) != '0);
    cf  = clr_first_we ? clr_first_mask : '0;
    cn  = clr_next_we ? clr_next_mask : '0;
    m_first = (m_first & ~cf) | fs;
    m_next  = (m_next & ~cn) | ns;
    if (cap) begin
      m_addr = err_addr; m_cmd = err_cmd; m_data = err_data;
    end
    m_cv     = (m_first & BM) != '0;
    m_single = (m_first != '0) && (m_next == '0);
    m_multi  = (m_first != '0) && (m_next != '0);
  endtask

  task automatic compare_all();
    check("R2 first_q", 64'(first_q), 64'(m_first));
    check("R3 next_q", 64'(next_q), 64'(m_next));
    check("R6 ctx_addr", 64'(ctx_addr), 64'(m_addr));
    check("R6 ctx_cmd", 64'(ctx_cmd), 64'(m_cmd));
    check("R6 ctx_data", 64'(ctx_data), 64'(m_data));
    check("R9 ctx_valid", 64'(ctx_valid), 64'(m_cv));
    check("R8 single_err", 64'(single_err), 64'(m_single));
    check("R8 multi_err", 64'(multi_err), 64'(m_multi));
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic cyc(input logic [NSRC-1:0] e, input logic cfw, input logic [NSRC-1:0] cfm,
                     input logic cnw, input logic [NSRC-1:0] cnm);
    err_vld = e; clr_first_we = cfw; clr_first_mask = cfm;
    clr_next_we = cnw; clr_next_mask = cnm;
    err_addr = $urandom; err_cmd = CW'($urandom); err_data = {$urandom, $urandom};
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] saved_addr;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1 first_q in reset", 64'(first_q), 64'd0);
    check("R1 single_err in reset", 64'(single_err), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first_q after reset", 64'(first_q), 64'd0);
    check("R1 next_q after reset", 64'(next_q), 64'd0);
    check("R1 ctx_addr after reset", 64'(ctx_addr), 64'd0);
    check("R1 multi_err after reset", 64'(multi_err), 64'd0);

    // R4: two blocking sources together into an empty log
    cyc(16'h0006, 1'b0, '0, 1'b0, '0);
    check("R4 same-cycle first", 64'(first_q), 64'h6);
    check("R4 same-cycle next", 64'(next_q), 64'h0);
    check("R8 single after first", 64'(single_err), 64'd1);
    saved_addr = ctx_addr;
    // R3: repeat of a source already held
    cyc(16'h0002, 1'b0, '0, 1'b0, '0);
    check("R3 repeat goes to next", 64'(next_q), 64'h2);
    check("R3 first unchanged", 64'(first_q), 64'h6);
    check("R6 ctx held", 64'(ctx_addr), 64'(saved_addr));
    check("R8 multi after repeat", 64'(multi_err), 64'd1);
    // R5: correctable bit is not blocked by held blocking bits
    cyc(16'h0001, 1'b0, '0, 1'b0, '0);
    check("R5 corr into first", 64'(first_q), 64'h7);
    cyc(16'h0001, 1'b0, '0, 1'b0, '0);
    check("R5 corr repeat into next", 64'(next_q), 64'h3);
    // R5: correctable bit alone in a clean log does not block a later blocking error
    cyc(16'h0000, 1'b1, 16'hFFFF, 1'b1, 16'hFFFF);
    cyc(16'h0001, 1'b0, '0, 1'b0, '0);
    check("R5 corr alone first", 64'(first_q), 64'h1);
    check("R9 corr alone no ctx_valid", 64'(ctx_valid), 64'd0);
    cyc(16'h0020, 1'b0, '0, 1'b0, '0);
    check("R5 blocking after corr", 64'(first_q), 64'h21);
    check("R5 blocking after corr next", 64'(next_q), 64'h0);
    // R7: full clear in the same cycle as a new error; pre-clear value routes it
    cyc(16'h0008, 1'b1, 16'hFFFF, 1'b1, 16'hFFFF);
    check("R7 clear with event first", 64'(first_q), 64'h0);
    check("R7 clear with event next", 64'(next_q), 64'h8);
    check("R9 ctx_valid after clear", 64'(ctx_valid), 64'd0);
    // R6: capture re-armed
    cyc(16'h0010, 1'b0, '0, 1'b0, '0);
    check("R6 re-armed first", 64'(first_q), 64'h10);
    check("R6 re-armed ctx", 64'(ctx_addr), 64'(m_addr));
    // R7: set wins over clear of the same bit
    cyc(16'h0008, 1'b0, '0, 1'b1, 16'h0008);
    check("R7 set wins", 64'(next_q), 64'h8);

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [NSRC-1:0] e, cm, nm;
      logic cw, nw;
      e  = ($urandom % 3 == 0) ? NSRC'($urandom & $urandom & $urandom) : '0;
      cw = ($urandom % 6 == 0);
      nw = ($urandom % 6 == 0);
      cm = ($urandom % 2 == 0) ? '1 : NSRC'($urandom);
      nm = ($urandom % 2 == 0) ? '1 : NSRC'($urandom);
      cyc(e, cw, cm, nw, nm);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule